// File: doc/BRIEF.md
# PN Spreading Code Modulator

This block spreads a transmit bit stream with a pseudo-noise chip code. The code lives in a fixed 256-entry, one-bit code table. Software picks a window inside that table with a base address and a length. Each chip tick then advances the code address one step through the window and wraps back to the base. The current data bit is XORed with the current chip to form the modulated output. A data-clock output marks the first half of every data-bit period. Three pin selects route each of the chip, data-clock and modulated signals to a pad, in place of a general-purpose value.

Transmit data reaches the block through register writes. A low-byte write is stored first; the high-byte write then forms a 16-bit word in the hold register and marks it valid. There is no back-pressure: a high-byte write made while the hold word is still valid replaces it. The data bit period has two sources. In length mode it equals one full code period. In independent mode it is a programmed number of chips. A stop-mode wake pulse restarts the sequencer and leaves every register as it was. Only the reset input clears the registers.

A length or divider value of 0 stands for 256.

Top module: `pnm_spread`

## Requirements
- R1: Reset clears every register to 0, and chip_o, dclk_o and mod_o are low.
- R2: Registers are at offsets 0 (control), 1 (code base), 2 (code length) and 5 (bit divider), and each reads back as written. Offsets 3 (hold low byte) and 4 (hold high byte) are write-only and read 0, as do offsets 6 and 7. Control bits: 0 enable, 1 go, 2 chip pad select, 3 data-clock pad select, 4 modulated pad select, 7 data clock mode (0 length, 1 independent).
- R3: The block runs only while enable and go are both 1. Otherwise chip_o, dclk_o and mod_o are 0, and the code address reloads from the base, so a start begins at the base entry.
- R4: On every cycle with chip_tick high while running, the code address moves to the next entry modulo 256. After base+length-1 it returns to the base.
- R5: chip_o is the table bit at the current address. The bit at address a is the XOR of the bits of (a AND 8'hB4), XORed with (a[1] AND a[6]).
- R6: In length mode each data bit lasts exactly length chips. dclk_o is high for the first ceil(length/2) chips of each bit.
- R7: In independent mode each data bit lasts divider chips while the code still cycles over length. dclk_o is high for the first ceil(divider/2) chips of each bit.
- R8: mod_o is the current data bit XOR chip_o.
- R9: A high-byte write forms the word {high, stored low} and marks it valid. The word moves to the shifter when the shifter is empty (at once while stopped, at a bit boundary while running) or after the shifter's 16th bit. Bits go out LSB first, and with no word in the shifter the data bit is 0.
- R10: pad_sel[i] equals control bit 2+i. pad_out[i] carries output i (0 chip, 1 data clock, 2 modulated) when selected and gpio_in[i] otherwise.
- R11: A stop_wake pulse returns the code address to the base, clears the bit counters and empties the shifter. All registers, the hold word included, keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low full reset |
| stop_wake | input | 1 | Stop-mode recovery pulse; sequencer only |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset for write and read |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| chip_tick | input | 1 | Chip clock enable |
| gpio_in | input | 3 | General-purpose values for unselected pads |
| chip_o | output | 1 | Current code chip |
| dclk_o | output | 1 | Data clock |
| mod_o | output | 1 | Spread data |
| pad_out | output | 3 | Muxed pad values |
| pad_sel | output | 3 | Pad select state |

## Verification
The code address, bit counters and shifter all change at the clock edge that samples a chip tick or a register write. chip_o, dclk_o, mod_o and the pads are combinational from that state. Each result is therefore due in the cycle right after its stimulus. The bench drives each stimulus for exactly one edge and samples 1 ns after that edge, well before the next edge. Loaded words are queued before the go write. That write's edge is the last stopped edge, so the first data bit is already in place at chip 0, and chip k is checked after exactly k ticks.

// File: rtl/pnm_pkg.sv
package pnm_pkg;
  localparam int CODE_AW = 8;
  localparam int REG_AW  = 3;
  localparam int REG_DW  = 8;
  localparam int WORD_W  = 16;
  localparam int NPADS   = 3;

  localparam logic [REG_AW-1:0] OFS_CTRL = 3'd0;
  localparam logic [REG_AW-1:0] OFS_BASE = 3'd1;
  localparam logic [REG_AW-1:0] OFS_LEN  = 3'd2;
  localparam logic [REG_AW-1:0] OFS_TXLO = 3'd3;
  localparam logic [REG_AW-1:0] OFS_TXHI = 3'd4;
  localparam logic [REG_AW-1:0] OFS_DIV  = 3'd5;

  localparam logic [CODE_AW-1:0] TAP_MASK = 8'hB4;

  // fixed code table content, evaluated at elaboration for each address
  function automatic logic code_bit(input logic [CODE_AW-1:0] a);
    return (^(a & TAP_MASK)) ^ (a[1] & a[6]);
  endfunction
endpackage

// File: rtl/pnm_regs.sv
module pnm_regs
  import pnm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [REG_DW-1:0] wdata,
  output logic [REG_DW-1:0] rdata,
  output logic              en,
  output logic              go,
  output logic [NPADS-1:0]  sel,
  output logic              indep,
  output logic [REG_DW-1:0] base_q,
  output logic [REG_DW-1:0] len_q,
  output logic [REG_DW-1:0] div_q,
  output logic [REG_DW-1:0] lo_q,
  output logic              hi_we
);
  logic [REG_DW-1:0] ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      base_q <= '0;
      len_q  <= '0;
      div_q  <= '0;
      lo_q   <= '0;
    end else if (wr_en) begin
      case (addr)
        OFS_CTRL: ctrl_q <= wdata;
        OFS_BASE: base_q <= wdata;
        OFS_LEN:  len_q  <= wdata;
        OFS_DIV:  div_q  <= wdata;
        OFS_TXLO: lo_q   <= wdata;
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      OFS_CTRL: rdata = ctrl_q;
      OFS_BASE: rdata = base_q;
      OFS_LEN:  rdata = len_q;
      OFS_DIV:  rdata = div_q;
      default:  rdata = '0;
    endcase
  end

  assign en    = ctrl_q[0];
  assign go    = ctrl_q[1];
  assign sel   = ctrl_q[2 +: NPADS];
  assign indep = ctrl_q[7];
  assign hi_we = wr_en && (addr == OFS_TXHI);
endmodule

// File: rtl/pnm_code_rom.sv
module pnm_code_rom
  import pnm_pkg::*;
#(
  parameter int AW = CODE_AW
) (
  input  logic [AW-1:0] addr,
  output logic          chip
);
  localparam int DEPTH = 1 << AW;
  logic [DEPTH-1:0] rom_bits;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    assign rom_bits[i] = code_bit(CODE_AW'(i));
  end

  assign chip = rom_bits[addr];
endmodule

// File: rtl/pnm_seq.sv
module pnm_seq
  import pnm_pkg::*;
#(
  parameter int AW = CODE_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wake,
  input  logic          run,
  input  logic          tick,
  input  logic          indep,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] len,
  input  logic [AW-1:0] div,
  output logic [AW-1:0] code_addr,
  output logic          bit_end,
  output logic          dclk
);
  logic [AW-1:0] ccnt, bcnt, code_last, bit_last;
  logic [AW:0]   half;
  logic          wrap_c, wrap_b;

  assign code_last = len - AW'(1);
  assign bit_last  = indep ? (div - AW'(1)) : code_last;
  assign wrap_c    = (ccnt == code_last);
  assign wrap_b    = (bcnt == bit_last);
  assign half      = ({1'b0, bit_last} + (AW+1)'(2)) >> 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_addr <= '0;
      ccnt      <= '0;
      bcnt      <= '0;
    end else if (wake || !run) begin
      code_addr <= base;
      ccnt      <= '0;
      bcnt      <= '0;
    end else if (tick) begin
      code_addr <= wrap_c ? base : code_addr + AW'(1);
      ccnt      <= wrap_c ? '0 : ccnt + AW'(1);
      bcnt      <= wrap_b ? '0 : bcnt + AW'(1);
    end
  end

  assign bit_end = run && tick && !wake && wrap_b;
  assign dclk    = run && ({1'b0, bcnt} < half);
endmodule

// File: rtl/pnm_data.sv
module pnm_data
  import pnm_pkg::*;
#(
  parameter int WW = WORD_W,
  parameter int BW = REG_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wake,
  input  logic          run,
  input  logic          bit_end,
  input  logic          hi_we,
  input  logic [BW-1:0] hi_byte,
  input  logic [BW-1:0] lo_byte,
  output logic          data_bit
);
  localparam int PW = $clog2(WW);

  logic [WW-1:0] hold_q, sh_q;
  logic          hold_v, sh_full;
  logic [PW-1:0] pos;
  logic          need_load;

  always_comb begin
    if (!sh_full) need_load = run ? bit_end : 1'b1;
    else          need_load = bit_end && (pos == PW'(WW-1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      hold_v  <= 1'b0;
      sh_q    <= '0;
      sh_full <= 1'b0;
      pos     <= '0;
    end else begin
      if (wake) begin
        sh_full <= 1'b0;
        pos     <= '0;
      end else if (need_load) begin
        pos <= '0;
        if (hold_v) begin
          sh_q    <= hold_q;
          sh_full <= 1'b1;
          hold_v  <= 1'b0;
        end else begin
          sh_full <= 1'b0;
        end
      end else if (bit_end && sh_full) begin
        sh_q <= sh_q >> 1;
        pos  <= pos + PW'(1);
      end
      if (hi_we) begin
        hold_q <= {hi_byte, lo_byte};
        hold_v <= 1'b1;
      end
    end
  end

  assign data_bit = sh_full && sh_q[0];
endmodule

// File: rtl/pnm_spread.sv
module pnm_spread
  import pnm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stop_wake,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  input  logic              chip_tick,
  input  logic [NPADS-1:0]  gpio_in,
  output logic              chip_o,
  output logic              dclk_o,
  output logic              mod_o,
  output logic [NPADS-1:0]  pad_out,
  output logic [NPADS-1:0]  pad_sel
);
  logic               en, go, indep, hi_we, run, bit_end, dclk, rom_chip, data_bit;
  logic [REG_DW-1:0]  base_q, len_q, div_q, lo_q;
  logic [CODE_AW-1:0] code_addr;
  logic [NPADS-1:0]   sel, srcs;

  pnm_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .en(en), .go(go), .sel(sel), .indep(indep),
    .base_q(base_q), .len_q(len_q), .div_q(div_q), .lo_q(lo_q), .hi_we(hi_we)
  );

  assign run = en && go;

  pnm_seq #(.AW(CODE_AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .wake(stop_wake), .run(run), .tick(chip_tick),
    .indep(indep), .base(base_q), .len(len_q), .div(div_q),
    .code_addr(code_addr), .bit_end(bit_end), .dclk(dclk)
  );

  pnm_code_rom #(.AW(CODE_AW)) u_rom (.addr(code_addr), .chip(rom_chip));

  pnm_data #(.WW(WORD_W), .BW(REG_DW)) u_data (
    .clk(clk), .rst_n(rst_n), .wake(stop_wake), .run(run), .bit_end(bit_end),
    .hi_we(hi_we), .hi_byte(reg_wdata), .lo_byte(lo_q), .data_bit(data_bit)
  );

  assign chip_o = run && rom_chip;
  assign dclk_o = dclk;
  assign mod_o  = run && (rom_chip ^ data_bit);

  assign srcs = {mod_o, dclk_o, chip_o};
  for (genvar i = 0; i < NPADS; i++) begin : g_pad
    assign pad_out[i] = sel[i] ? srcs[i] : gpio_in[i];
  end
  assign pad_sel = sel;
endmodule

// File: rtl/pnm_checker.sv
module pnm_checker
  import pnm_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               stop_wake,
  input logic               chip_tick,
  input logic               run,
  input logic [CODE_AW-1:0] code_addr,
  input logic [REG_DW-1:0]  base_q,
  input logic [REG_DW-1:0]  len_q,
  input logic               chip_o,
  input logic               dclk_o,
  input logic               mod_o,
  input logic [NPADS-1:0]   pad_out,
  input logic [NPADS-1:0]   pad_sel,
  input logic [NPADS-1:0]   gpio_in
);
  a_r3_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!chip_o && !dclk_o && !mod_o));

  a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (!run || stop_wake) |=> (code_addr == $past(base_q)));

  // R4: a step inside the window (base and length held while running)
  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run && chip_tick && !stop_wake && ((code_addr - base_q) != (len_q - 8'd1)))
    |=> (code_addr == $past(code_addr) + 8'd1));

  a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (run && chip_tick && !stop_wake && ((code_addr - base_q) == (len_q - 8'd1)))
    |=> (code_addr == $past(base_q)));

  a_r6_dclk_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> dclk_o);

  a_r10_gpio_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_sel == '0) |-> (pad_out == gpio_in));
endmodule

bind pnm_spread pnm_checker u_chk (
  .clk(clk), .rst_n(rst_n), .stop_wake(stop_wake), .chip_tick(chip_tick),
  .run(run), .code_addr(code_addr), .base_q(base_q), .len_q(len_q),
  .chip_o(chip_o), .dclk_o(dclk_o), .mod_o(mod_o),
  .pad_out(pad_out), .pad_sel(pad_sel), .gpio_in(gpio_in)
);

// File: tb/pnm_spread_bench.sv
module pnm_spread_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stop_wake = 1'b0;
  logic       reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       chip_tick = 1'b0;
  logic [2:0] gpio_in = '0;
  logic       chip_o, dclk_o, mod_o;
  logic [2:0] pad_out, pad_sel;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  pnm_spread u_pnm_spread (
    .clk(clk), .rst_n(rst_n), .stop_wake(stop_wake), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .chip_tick(chip_tick), .gpio_in(gpio_in), .chip_o(chip_o), .dclk_o(dclk_o),
    .mod_o(mod_o), .pad_out(pad_out), .pad_sel(pad_sel)
  );

  function automatic logic tbl(input logic [7:0] a);
    return (^(a & 8'hB4)) ^ (a[1] & a[6]);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic t);
    chip_tick = t;
    @(posedge clk);
    #1;
    chip_tick = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    #1;
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
    reg_addr = a;
    #1;
    chk(req, reg_rdata, exp);
  endtask

  task automatic t_reset;
    for (int a = 0; a < 8; a++) rd_chk("R1 reg", 3'(a), 8'h00);
    chk("R1 outputs", {chip_o, dclk_o, mod_o}, 3'b000);
  endtask

  task automatic t_regs;
    wr(3'd1, 8'h3C); wr(3'd2, 8'h07); wr(3'd5, 8'h05); wr(3'd0, 8'h60);
    rd_chk("R2 base", 3'd1, 8'h3C);
    rd_chk("R2 len", 3'd2, 8'h07);
    rd_chk("R2 div", 3'd5, 8'h05);
    rd_chk("R2 ctrl", 3'd0, 8'h60);
    wr(3'd3, 8'hAA);
    rd_chk("R2 lo write-only", 3'd3, 8'h00);
    rd_chk("R2 hi write-only", 3'd4, 8'h00);
    rd_chk("R2 unused", 3'd6, 8'h00);
    chk("R3 not running", {chip_o, dclk_o, mod_o}, 3'b000);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_idle;
    wr(3'd1, 8'd9); wr(3'd2, 8'd3); wr(3'd0, 8'h01);
    for (int k = 0; k < 5; k++) begin
      chk("R3 enable without go", {chip_o, dclk_o, mod_o}, 3'b000);
      cyc(1'b1);
    end
    wr(3'd0, 8'h02);
    cyc(1'b1);
    chk("R3 go without enable", {chip_o, dclk_o, mod_o}, 3'b000);
    wr(3'd0, 8'h03);
    chk("R3 start at base", chip_o, tbl(8'd9));
    chk("R6 dclk at start", dclk_o, 1'b1);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_wrap;
    wr(3'd1, 8'd250); wr(3'd2, 8'd10); wr(3'd0, 8'h03);
    for (int k = 0; k < 25; k++) begin
      chk("R4 R5 chip sequence", chip_o, tbl(8'(250 + (k % 10))));
      chk("R8 no data", mod_o, chip_o);
      cyc(1'b1);
    end
    wr(3'd0, 8'h00);
  endtask

  task automatic t_length;
    logic [31:0] words;
    logic        db;
    words = 32'h3E71_A5C3;
    wr(3'd1, 8'd16); wr(3'd2, 8'd2);
    wr(3'd3, 8'hC3); wr(3'd4, 8'hA5);
    wr(3'd3, 8'h71); wr(3'd4, 8'h3E);
    wr(3'd0, 8'h03);
    for (int k = 0; k < 68; k++) begin
      db = (k / 2 < 32) ? words[k / 2] : 1'b0;
      chk("R5 chip", chip_o, tbl(8'(16 + (k % 2))));
      chk("R6 dclk length mode", dclk_o, (k % 2) < 1);
      chk("R8 R9 modulated", mod_o, tbl(8'(16 + (k % 2))) ^ db);
      cyc(1'b1);
    end
    wr(3'd0, 8'h00);
  endtask

  task automatic t_indep;
    logic [15:0] w;
    logic        db;
    w = 16'h9B2D;
    wr(3'd1, 8'd100); wr(3'd2, 8'd5); wr(3'd5, 8'd3);
    wr(3'd3, 8'h2D); wr(3'd4, 8'h9B);
    wr(3'd0, 8'h83);
    for (int k = 0; k < 51; k++) begin
      db = (k / 3 < 16) ? w[k / 3] : 1'b0;
      chk("R7 chip", chip_o, tbl(8'(100 + (k % 5))));
      chk("R7 dclk independent", dclk_o, (k % 3) < 2);
      chk("R7 R8 modulated", mod_o, tbl(8'(100 + (k % 5))) ^ db);
      cyc(1'b1);
    end
    wr(3'd0, 8'h00);
  endtask

  task automatic t_pads;
    gpio_in = 3'b101;
    wr(3'd1, 8'd7); wr(3'd2, 8'd4); wr(3'd0, 8'h1F);
    cyc(1'b1);
    chk("R10 all selected", pad_out, {mod_o, dclk_o, chip_o});
    chk("R10 sel", pad_sel, 3'b111);
    wr(3'd0, 8'h03);
    chk("R10 none selected", pad_out, gpio_in);
    wr(3'd0, 8'h0B);
    chk("R10 dclk only", pad_out, {gpio_in[2], dclk_o, gpio_in[0]});
    chk("R10 sel dclk", pad_sel, 3'b010);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_wake;
    wr(3'd1, 8'd40); wr(3'd2, 8'd6); wr(3'd0, 8'h03);
    cyc(1'b1); cyc(1'b1); cyc(1'b1);
    chk("R4 before wake", chip_o, tbl(8'd43));
    stop_wake = 1'b1;
    cyc(1'b0);
    stop_wake = 1'b0;
    chk("R11 address at base", chip_o, tbl(8'd40));
    chk("R11 dclk restarted", dclk_o, 1'b1);
    rd_chk("R11 base kept", 3'd1, 8'd40);
    rd_chk("R11 len kept", 3'd2, 8'd6);
    rd_chk("R11 ctrl kept", 3'd0, 8'h03);
    cyc(1'b1);
    chk("R11 continues", chip_o, tbl(8'd41));
  endtask

  task automatic t_rst;
    rst_n = 1'b0;
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    rd_chk("R1 ctrl cleared", 3'd0, 8'h00);
    rd_chk("R1 base cleared", 3'd1, 8'h00);
    chk("R1 outputs low", {chip_o, dclk_o, mod_o}, 3'b000);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_idle();
    t_wrap();
    t_length();
    t_indep();
    t_pads();
    t_wake();
    t_rst();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule